// File: doc/BRIEF.md
# Diminished-One Modular Multiply-Accumulate Compressor

This block is the combining stage of a lattice hash. It receives a stream of transform vectors, each holding 64 coefficients modulo the Fermat prime 257. It folds every group of 16 consecutive vectors into one 64-entry hash vector, which stays in the Fourier domain. Every coefficient travels in diminished-one form: a nonzero value v is carried as v-1 on 8 bits, and a separate flag marks the value zero.

Each lane holds a lookup table indexed by the column counter and the incoming operand. The table returns a modular product in a single registered cycle. A diminished-one modular adder then adds that product into the lane's accumulator.

The table stores products with the diminished operand, so every lane also needs a correction term: the sum of its 16 constants. That term is the preset value of the accumulator. After each finished block the accumulator is reloaded with this preset, which costs one cycle. During that cycle the block holds off its input, so one block passes every 17 cycles.

Top module: `dmo_mac_compressor`

## Requirements
- R1: When the done strobe `out_valid` is high, lane i reports Z_i = sum over columns j of A(i,j)*Y(i,j) mod 257. The lane's diminished value sits at `out_dim[i*8 +: 8]` and its zero flag at `out_zero[i]`. A zero result shows the flag set and a diminished value of 0; a nonzero result Z shows the value Z-1.
- R2: The constants are A(i,j) = (97*i + 61*j + 29*(i XOR j) + SEED) mod 257, with SEED = 11 by default. The column index j is the position of the vector within its block, in order of acceptance, starting at 0.
- R3: An input coefficient with its zero flag set adds nothing to the result, whatever its diminished bits hold.
- R4: `out_valid` rises on the first clock edge after the edge that accepts the 16th vector of a block.
- R5: `out_valid` stays high for exactly one cycle per completed block.
- R6: `in_ready` is low for exactly the one cycle after the edge that accepts a block's 16th vector, and high at all other times. Blocks sent back to back therefore complete 17 cycles apart.
- R7: Cycles with `in_valid` low inside a block change neither the column count nor the result.
- R8: A vector accepted with `in_first` high is column 0 of a new block. Any partial block in progress is discarded and produces no done strobe.
- R9: After reset `out_valid` is low and `in_ready` is high, and the first accepted vector is column 0 even when `in_first` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector is present |
| in_first | input | 1 | Input vector starts a new block |
| in_dim | input | LANES*KW | Diminished-one coefficients, lane i at bits i*KW upward |
| in_zero | input | LANES | Zero flags of the coefficients |
| in_ready | output | 1 | Block can take a vector this cycle |
| out_valid | output | 1 | One-cycle done strobe |
| out_dim | output | LANES*KW | Accumulated diminished-one results |
| out_zero | output | LANES | Zero flags of the results |

## Verification
The bench first targets operands that stress the diminished-one adder. Blocks of all-zero coefficients must give an exact zero in every lane. Blocks of all-maximum operands (value 256, that is -1) hit the carry-out and wrap-to-zero paths. A broken zero detector or carry path shows up there as a result that is off by one. Mixed blocks where a third of the coefficients are zero expose a design that forgets the zero-operand correction entry: every lane then carries an extra constant.

Blocks are sent back to back to check the 17-cycle spacing and the single stall cycle. A design that skips the stall would merge the preset reload with the next block's first column. Gaps inside a block catch a counter that advances on idle cycles. An abandoned partial block followed by a restart catches stale partial sums and spurious done strobes.

// File: rtl/dmo_pkg.sv
`timescale 1ns/1ps
package dmo_pkg;

  // Per-lane, per-column multiplier constant, in plain (non-diminished) form.
  function automatic int unsigned dmo_coef(input int unsigned lane,
                                           input int unsigned col,
                                           input int unsigned seed,
                                           input int unsigned prime);
    return (97 * lane + 61 * col + 29 * (lane ^ col) + seed) % prime;
  endfunction

  // Correction term of one lane: sum of its constants modulo the prime.
  function automatic int unsigned dmo_preset(input int unsigned lane,
                                             input int unsigned cols,
                                             input int unsigned seed,
                                             input int unsigned prime);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < cols; j++) begin
      acc = (acc + dmo_coef(lane, j, seed, prime)) % prime;
    end
    return acc;
  endfunction

endpackage

// File: rtl/dmo_dim_adder.sv
`timescale 1ns/1ps
// Modular adder for residues modulo 2**KW+1 held in diminished-one form.
module dmo_dim_adder #(
  parameter int KW = 8
) (
  input  logic [KW-1:0] a_dim,
  input  logic          a_zero,
  input  logic [KW-1:0] b_dim,
  input  logic          b_zero,
  output logic [KW-1:0] s_dim,
  output logic          s_zero
);
  logic [KW:0] raw;

  always_comb begin
    raw = {1'b0, a_dim} + {1'b0, b_dim};
    if (a_zero) begin
      s_dim  = b_dim;
      s_zero = b_zero;
    end else if (b_zero) begin
      s_dim  = a_dim;
      s_zero = a_zero;
    end else if (raw[KW]) begin
      // Carry out: the end-around increment is absorbed by the wrap.
      s_dim  = raw[KW-1:0];
      s_zero = 1'b0;
    end else if (&raw[KW-1:0]) begin
      // Sum reaches the modulus exactly.
      s_dim  = '0;
      s_zero = 1'b1;
    end else begin
      s_dim  = raw[KW-1:0] + KW'(1);
      s_zero = 1'b0;
    end
  end
endmodule

// File: rtl/dmo_lane_table.sv
`timescale 1ns/1ps
// Per-lane product table addressed by {column, operand}. Entry contents are
// defined by a closed-form function of the address; the read is registered.
// Operand entries hold A*Ydim mod p; the zero-operand entry holds -A mod p so
// that the preset correction is cancelled for a zero coefficient.
module dmo_lane_table #(
  parameter int LANE = 0,
  parameter int COLS = 16,
  parameter int KW   = 8,
  parameter int SEED = 11,
  localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int PRIME = (1 << KW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [CW-1:0] col,
  input  logic [KW-1:0] op_dim,
  input  logic          op_zero,
  output logic [KW-1:0] prod_dim,
  output logic          prod_zero
);
  import dmo_pkg::*;

  logic [KW:0] coef [COLS];

  for (genvar j = 0; j < COLS; j++) begin : g_coef
    assign coef[j] = (KW+1)'(dmo_coef(LANE, j, SEED, PRIME));
  end

  logic [KW:0]     a_sel;
  logic [2*KW-1:0] full;
  logic [KW-1:0]   lo_part;
  logic [KW-1:0]   hi_part;
  logic [KW:0]     residue;
  logic [KW-1:0]   entry_dim;
  logic            entry_zero;

  always_comb begin
    a_sel   = coef[col];
    full    = (2*KW)'(a_sel) * (2*KW)'(op_dim);
    lo_part = full[KW-1:0];
    hi_part = full[2*KW-1:KW];
    if (op_zero) begin
      residue = (a_sel == '0) ? '0 : ((KW+1)'(PRIME) - a_sel);
    end else if (lo_part >= hi_part) begin
      residue = {1'b0, lo_part} - {1'b0, hi_part};
    end else begin
      residue = {1'b0, lo_part} + (KW+1)'(PRIME) - {1'b0, hi_part};
    end
    entry_zero = (residue == '0);
    entry_dim  = entry_zero ? '0 : KW'(residue - (KW+1)'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_dim  <= '0;
      prod_zero <= 1'b1;
    end else if (rd_en) begin
      prod_dim  <= entry_dim;
      prod_zero <= entry_zero;
    end
  end
endmodule

// File: rtl/dmo_lane_acc.sv
`timescale 1ns/1ps
// Accumulator of one lane, preset to the lane's correction term.
module dmo_lane_acc #(
  parameter int LANE = 0,
  parameter int COLS = 16,
  parameter int KW   = 8,
  parameter int SEED = 11,
  localparam int PRIME = (1 << KW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic          restart,
  input  logic          clear,
  input  logic [KW-1:0] prod_dim,
  input  logic          prod_zero,
  output logic [KW-1:0] acc_dim,
  output logic          acc_zero
);
  import dmo_pkg::*;

  localparam int unsigned PSUM    = dmo_preset(LANE, COLS, SEED, PRIME);
  localparam logic        PZERO   = (PSUM == 0);
  localparam logic [KW-1:0] PDIM  = (PSUM == 0) ? '0 : KW'(PSUM - 1);

  logic [KW-1:0] base_dim;
  logic          base_zero;
  logic [KW-1:0] sum_dim;
  logic          sum_zero;
  logic [KW-1:0] acc_dim_d;
  logic          acc_zero_d;
  logic          acc_en;

  always_comb begin
    base_dim  = restart ? PDIM  : acc_dim;
    base_zero = restart ? PZERO : acc_zero;
  end

  dmo_dim_adder #(.KW(KW)) u_add (
    .a_dim  (base_dim),
    .a_zero (base_zero),
    .b_dim  (prod_dim),
    .b_zero (prod_zero),
    .s_dim  (sum_dim),
    .s_zero (sum_zero)
  );

  always_comb begin
    acc_en     = add_en | clear;
    acc_dim_d  = acc_dim;
    acc_zero_d = acc_zero;
    if (add_en) begin
      acc_dim_d  = sum_dim;
      acc_zero_d = sum_zero;
    end else if (clear) begin
      acc_dim_d  = PDIM;
      acc_zero_d = PZERO;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_dim  <= PDIM;
      acc_zero <= PZERO;
    end else if (acc_en) begin
      acc_dim  <= acc_dim_d;
      acc_zero <= acc_zero_d;
    end
  end
endmodule

// File: rtl/dmo_col_ctrl.sv
`timescale 1ns/1ps
// Column counter, stall insertion and done-strobe timing shared by all lanes.
module dmo_col_ctrl #(
  parameter int COLS = 16,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  output logic          in_ready,
  output logic          accept,
  output logic [CW-1:0] col_eff,
  output logic          p_valid,
  output logic          p_restart,
  output logic          done
);
  localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

  logic [CW-1:0] col_q, col_d;
  logic          stall_q, stall_d;
  logic          pv_q, pv_d;
  logic          plast_q, plast_d;
  logic          prest_q, prest_d;
  logic          done_q, done_d;
  logic          is_last;

  always_comb begin
    in_ready = ~stall_q;
    accept   = in_valid & in_ready;
    col_eff  = in_first ? '0 : col_q;
    is_last  = (col_eff == LAST_COL);

    col_d   = col_q;
    if (accept) begin
      col_d = is_last ? '0 : col_eff + CW'(1);
    end
    stall_d = accept & is_last;
    pv_d    = accept;
    plast_d = accept & is_last;
    prest_d = accept & (col_eff == '0);
    done_d  = pv_q & plast_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      stall_q <= 1'b0;
      pv_q    <= 1'b0;
      plast_q <= 1'b0;
      prest_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        col_q <= col_d;
      end
      stall_q <= stall_d;
      pv_q    <= pv_d;
      plast_q <= plast_d;
      prest_q <= prest_d;
      done_q  <= done_d;
    end
  end

  assign p_valid   = pv_q;
  assign p_restart = prest_q;
  assign done      = done_q;
endmodule

// File: rtl/dmo_mac_compressor.sv
`timescale 1ns/1ps
module dmo_mac_compressor #(
  parameter int LANES = 64,
  parameter int COLS  = 16,
  parameter int KW    = 8,
  parameter int SEED  = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_first,
  input  logic [LANES*KW-1:0] in_dim,
  input  logic [LANES-1:0]    in_zero,
  output logic                in_ready,
  output logic                out_valid,
  output logic [LANES*KW-1:0] out_dim,
  output logic [LANES-1:0]    out_zero
);
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic          accept;
  logic [CW-1:0] col_eff;
  logic          p_valid;
  logic          p_restart;
  logic          done;

  dmo_col_ctrl #(.COLS(COLS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_ready  (in_ready),
    .accept    (accept),
    .col_eff   (col_eff),
    .p_valid   (p_valid),
    .p_restart (p_restart),
    .done      (done)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [KW-1:0] prod_dim;
    logic          prod_zero;
    logic [KW-1:0] acc_dim;
    logic          acc_zero;

    dmo_lane_table #(.LANE(i), .COLS(COLS), .KW(KW), .SEED(SEED)) u_tab (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (accept),
      .col       (col_eff),
      .op_dim    (in_dim[i*KW +: KW]),
      .op_zero   (in_zero[i]),
      .prod_dim  (prod_dim),
      .prod_zero (prod_zero)
    );

    dmo_lane_acc #(.LANE(i), .COLS(COLS), .KW(KW), .SEED(SEED)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .add_en    (p_valid),
      .restart   (p_restart),
      .clear     (done),
      .prod_dim  (prod_dim),
      .prod_zero (prod_zero),
      .acc_dim   (acc_dim),
      .acc_zero  (acc_zero)
    );

    assign out_dim[i*KW +: KW] = acc_dim;
    assign out_zero[i]         = acc_zero;
  end

  assign out_valid = done;
endmodule

// File: rtl/dmo_mac_checker.sv
`timescale 1ns/1ps
module dmo_mac_checker #(
  parameter int LANES = 64,
  parameter int KW    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic [LANES*KW-1:0] out_dim,
  input logic [LANES-1:0]    out_zero
);
  logic [LANES*KW-1:0] zero_wide;

  for (genvar l = 0; l < LANES; l++) begin : g_zw
    assign zero_wide[l*KW +: KW] = {KW{out_zero[l]}};
  end

  // R5: done strobe lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6: the stall lasts exactly one cycle
  a_r6_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R4: the done strobe follows the stall cycle
  a_r4_done_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> out_valid);

  // R6: every done strobe is preceded by the stall cycle
  a_r6_done_has_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(!in_ready));

  // R1: zero-flagged results carry a cleared diminished value
  a_r1_zero_dim_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_dim & zero_wide) == '0));
endmodule

bind dmo_mac_compressor dmo_mac_checker #(.LANES(LANES), .KW(KW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_dim   (out_dim),
  .out_zero  (out_zero)
);

// File: tb/sim_dmo_mac_compressor.sv
`timescale 1ns/1ps
module sim_dmo_mac_compressor;
  localparam int LANES = 64;
  localparam int COLS  = 16;
  localparam int KW    = 8;
  localparam int SEED  = 11;
  localparam int P     = 257;

  logic                clk;
  logic                rst_n;
  logic                in_valid;
  logic                in_first;
  logic [LANES*KW-1:0] in_dim;
  logic [LANES-1:0]    in_zero;
  logic                in_ready;
  logic                out_valid;
  logic [LANES*KW-1:0] out_dim;
  logic [LANES-1:0]    out_zero;

  dmo_mac_compressor #(.LANES(LANES), .COLS(COLS), .KW(KW), .SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_dim(in_dim), .in_zero(in_zero), .in_ready(in_ready),
    .out_valid(out_valid), .out_dim(out_dim), .out_zero(out_zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [KW-1:0] bd [COLS][LANES];
  logic          bz [COLS][LANES];

  logic [LANES*KW-1:0] exp_dim_q [$];
  logic [LANES-1:0]    exp_zero_q [$];
  int                  exp_cyc_q [$];
  int                  done_cyc [$];
  int                  pushed = 0;
  int                  seen = 0;
  logic [31:0]         rng = 32'h1234_5678;

  function automatic int coef_a(int lane, int col);
    return (97 * lane + 61 * col + 29 * (lane ^ col) + SEED) % P;
  endfunction

  function automatic logic [31:0] next_rng(logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic fill_random(int zero_every);
    for (int j = 0; j < COLS; j++) begin
      for (int l = 0; l < LANES; l++) begin
        rng = next_rng(rng);
        bd[j][l] = rng[KW-1:0];
        bz[j][l] = (zero_every > 0) && ((rng[15:8] % zero_every) == 0);
      end
    end
  endtask

  task automatic fill_const(logic [KW-1:0] d, logic z);
    for (int j = 0; j < COLS; j++)
      for (int l = 0; l < LANES; l++) begin
        bd[j][l] = d;
        bz[j][l] = z;
      end
  endtask

  task automatic push_expected(int when);
    logic [LANES*KW-1:0] ed;
    logic [LANES-1:0]    ez;
    for (int l = 0; l < LANES; l++) begin
      int acc = 0;
      for (int j = 0; j < COLS; j++) begin
        int y = bz[j][l] ? 0 : int'(bd[j][l]) + 1;
        acc = (acc + coef_a(l, j) * y) % P;
      end
      ez[l] = (acc == 0);
      ed[l*KW +: KW] = (acc == 0) ? '0 : KW'(acc - 1);
    end
    exp_dim_q.push_back(ed);
    exp_zero_q.push_back(ez);
    exp_cyc_q.push_back(when);
    pushed++;
  endtask

  task automatic send_vec(int j, bit first);
    @(negedge clk);
    in_valid = 1'b1;
    in_first = first;
    for (int l = 0; l < LANES; l++) begin
      in_dim[l*KW +: KW] = bd[j][l];
      in_zero[l]         = bz[j][l];
    end
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
    end
  endtask

  // Full block; gap > 0 inserts idle cycles after every fourth vector (R7).
  task automatic send_block(bit use_first, int gap);
    for (int j = 0; j < COLS; j++) begin
      send_vec(j, use_first && (j == 0));
      if (gap > 0 && (j % 4) == 3 && j != COLS - 1) idle(gap);
    end
    @(negedge clk);
    // R6: ready drops for the cycle after the last column is taken
    check(in_ready == 1'b0, "R6 stall after last column", in_ready, 0);
    // R4: done is expected one edge after the last accept
    push_expected(cyc + 1);
  endtask

  // Scoreboard monitor
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_valid) check(out_valid == 1'b0, "R5 single-cycle done", out_valid, 0);
      if (out_valid) begin
        seen++;
        done_cyc.push_back(cyc);
        if (exp_dim_q.size() == 0) begin
          check(1'b0, "R8 unexpected done strobe", seen, pushed);
        end else begin
          logic [LANES*KW-1:0] ed;
          logic [LANES-1:0]    ez;
          int                  ec;
          ed = exp_dim_q.pop_front();
          ez = exp_zero_q.pop_front();
          ec = exp_cyc_q.pop_front();
          check(cyc == ec, "R4 done latency", cyc, ec);
          for (int l = 0; l < LANES; l++) begin
            check(out_zero[l] == ez[l], "R1 zero flag", out_zero[l], ez[l]);
            check(out_dim[l*KW +: KW] == ed[l*KW +: KW], "R1 R2 lane value",
                  out_dim[l*KW +: KW], ed[l*KW +: KW]);
          end
        end
      end
      prev_valid <= out_valid;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_first = 1'b0;
    in_dim   = '0;
    in_zero  = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);

    // R9 first block without in_first; R1 R2 random data
    fill_random(0);
    send_block(1'b0, 0);
    // R3 mixed zero flags, sent back to back (R6 throughput)
    fill_random(3);
    send_block(1'b1, 0);
    idle(3);
    check(done_cyc.size() == 2, "R6 two blocks done", done_cyc.size(), 2);
    if (done_cyc.size() == 2)
      check(done_cyc[1] - done_cyc[0] == 17, "R6 block spacing",
            done_cyc[1] - done_cyc[0], 17);

    // R3 every coefficient zero-flagged: every lane must be zero
    fill_const(8'hA5, 1'b1);
    send_block(1'b1, 0);
    // R1 all operands at maximum (value 256)
    fill_const(8'hFF, 1'b0);
    send_block(1'b0, 0);
    idle(2);

    // R7 gaps inside a block
    fill_random(5);
    send_block(1'b1, 2);
    idle(2);

    // R8 partial block abandoned, then a restart with in_first
    fill_random(0);
    for (int j = 0; j < 7; j++) send_vec(j, 1'b0);
    idle(3);
    fill_random(4);
    send_block(1'b1, 0);

    repeat (10) @(negedge clk);
    check(exp_dim_q.size() == 0, "R4 all results delivered", exp_dim_q.size(), 0);
    check(seen == pushed, "R8 done strobe count", seen, pushed);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule